// File: doc/BRIEF.md
# Calendar Clock Core with Update Inhibit

This block keeps wall-clock time and a calendar in a small byte register file. It holds seconds, minutes, hours, day of week, date, month and year, plus three alarm bytes. Once per second, an external one-hertz pulse triggers one update step. The step carries through minutes, hours, days, months and years. The step runs in a single clock cycle, either in packed-decimal (BCD) or in plain binary, and it counts hours in either 12-hour or 24-hour form. The encoding and the hour form are chosen at run time by the control register.

Software uses a byte-wide select/write-enable bus to read and write every time byte, the control register and an event-flag register. Setting the inhibit bit of the control register freezes counting, so all time bytes can be loaded consistently. A write that sets this bit in the same cycle as a tick cancels that tick's update.

The block raises three kinds of event: periodic, alarm and update-done. Each event latches a flag, and each flag can be enabled onto a single interrupt line. The flags clear when the flag register is read. A square-wave input is gated onto an output pin by a control bit. Stored bytes are never converted when the encoding or hour form changes: software reloads them.

Top module: `rtc_core`

## Requirements
- R1: After reset, the control register (index 0x0B) reads 0x02. Seconds, minutes, hours, year and the three alarm bytes read 0x00. Day of week, date and month read 0x01. The flag register (index 0x0C) reads 0x00 and `irq` is low. Indices 0x0A and 0x0D to 0x0F always read 0x00.
- R2: When control bit 7 is 0, each `upd_tick` pulse advances the time bytes by one second. When control bit 7 is 1, ticks leave every time byte unchanged.
- R3: A bus write to the control register with data bit 7 set, made in the same cycle as `upd_tick`, cancels that update. The time bytes keep their values and no update-done flag is raised.
- R4: With control bit 2 at 0, values are BCD. Seconds and minutes roll from 0x59 to 0x00, each rollover carrying into the next field.
- R5: With control bit 2 at 1, values are binary. Seconds and minutes roll from 59 to 0, hours from 23 to 0, and the year from 99 to 0.
- R6: With control bit 1 at 1, hours count 0 to 23. A step from 23 goes to 0 and advances the day.
- R7: With control bit 1 at 0, hours byte bit 7 is the PM flag and the low bits count 12, 1 to 11. A step from 11 goes to 12 and toggles PM. A step from 11 PM to 12 AM advances the day. A step from 12 goes to 1 with PM unchanged.
- R8: On a day carry, day of week steps 1 to 7 and wraps to 1. The date wraps to 1 after the month's last day. Months 4, 6, 9 and 11 have 30 days, and February has 29 days when the year value is divisible by 4, otherwise 28. Other months have 31 days. The month wraps from 12 to 1 with a year carry, and the year wraps from 99 to 0.
- R9: An update whose new seconds, minutes and hours (indices 0, 2, 4) each equal the matching alarm byte (indices 1, 3, 5) sets the alarm flag. An alarm byte with bits 7 and 6 both set matches any value.
- R10: Flag register bit 6 is the periodic flag, set by `per_tick`. Bit 5 is the alarm flag. Bit 4 is the update-done flag, set by every completed update. Bit 7 reads the current `irq`, and bits 3 to 0 read 0. A read of the flag register clears bits 6 to 4. A flag set in the same cycle as that read survives it.
- R11: `irq` is high exactly when some flag is set and its enable is set. Control bit 6 enables periodic, bit 5 enables alarm and bit 4 enables update-done.
- R12: `sqw_out` equals `sqw_src` when control bit 3 is 1, and is 0 otherwise.
- R13: Every time, alarm and control byte reads back what was written. A write to a time byte in the same cycle as an update wins for that byte, while the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_tick | input | 1 | One-second update pulse, one cycle wide |
| per_tick | input | 1 | Periodic event pulse from the external rate divider |
| sqw_src | input | 1 | Square wave to be gated |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Combined interrupt request |
| sqw_out | output | 1 | Gated square wave |

## Verification
Three pairs of events can land in the same cycle. A flag-register read can coincide with a tick that raises the update-done and periodic flags. A write that sets the inhibit bit can coincide with a tick. A write to the seconds byte can coincide with an update. The bench drives each pair in one cycle. A behavioural model predicts the outcome: the new flag survives the read, the tick is discarded, and the written byte wins while minutes still carry. Both the bus read data and the interrupt line are compared on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W    = 8;
  localparam int VAL_W     = 7;
  localparam int NUM_TREGS = 10;
  localparam int NUM_ALM   = 3;

  localparam int IX_SEC   = 0;
  localparam int IX_ASEC  = 1;
  localparam int IX_MIN   = 2;
  localparam int IX_AMIN  = 3;
  localparam int IX_HOUR  = 4;
  localparam int IX_AHOUR = 5;
  localparam int IX_DOW   = 6;
  localparam int IX_DATE  = 7;
  localparam int IX_MON   = 8;
  localparam int IX_YEAR  = 9;
  localparam int IX_CTRL  = 11;
  localparam int IX_FLAG  = 12;

  localparam int CB_INH = 7;
  localparam int CB_SQW = 3;
  localparam int CB_BIN = 2;
  localparam int CB_H24 = 1;
  localparam int CB_ENLO = 4;
  localparam int NUM_FLAGS = 3;

  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h02;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [VAL_W-1:0]  val_t;

  typedef struct packed {
    byte_t sec;
    byte_t min;
    byte_t hour;
    byte_t dow;
    byte_t date;
    byte_t mon;
    byte_t year;
  } rtc_time_t;

  function automatic val_t val_dec(input byte_t v, input logic bin);
    val_t r;
    if (bin) r = v[VAL_W-1:0];
    else     r = {3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]};
    return r;
  endfunction

  function automatic byte_t val_enc(input val_t b, input logic bin);
    val_t  tens;
    val_t  ones;
    byte_t r;
    tens = b / 7'd10;
    ones = b - tens * 7'd10;
    if (bin) r = {1'b0, b};
    else     r = {tens[3:0], ones[3:0]};
    return r;
  endfunction

  function automatic byte_t treg_rst(input int idx);
    return (idx == IX_DOW || idx == IX_DATE || idx == IX_MON) ? byte_t'(1) : byte_t'(0);
  endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      bin,
  input  logic      h24,
  output rtc_time_t nxt
);
  val_t  s_b, m_b, h_b, dw_b, dt_b, mo_b, y_b, dim, h_new;
  logic  c_hr, c_min, c_day, c_mon, c_yr, pm;
  byte_t h_enc;

  always_comb begin
    nxt   = cur;
    c_day = 1'b0;
    h_new = '0;
    pm    = cur.hour[7];
    s_b   = val_dec(cur.sec, bin);
    m_b   = val_dec(cur.min, bin);
    dw_b  = val_dec(cur.dow, bin);
    dt_b  = val_dec(cur.date, bin);
    mo_b  = val_dec(cur.mon, bin);
    y_b   = val_dec(cur.year, bin);
    h_b   = h24 ? val_dec(cur.hour, bin) : val_dec({1'b0, cur.hour[6:0]}, bin);

    c_min   = (s_b >= 7'd59);
    nxt.sec = val_enc(c_min ? 7'd0 : s_b + 7'd1, bin);

    c_hr = c_min && (m_b >= 7'd59);
    if (c_min) nxt.min = val_enc(c_hr ? 7'd0 : m_b + 7'd1, bin);

    if (h24) begin
      c_day = c_hr && (h_b >= 7'd23);
      h_new = c_day ? 7'd0 : h_b + 7'd1;
    end else if (h_b == 7'd11) begin
      c_day = c_hr && cur.hour[7];
      pm    = ~cur.hour[7];
      h_new = 7'd12;
    end else begin
      h_new = (h_b >= 7'd12) ? 7'd1 : h_b + 7'd1;
    end
    h_enc = val_enc(h_new, bin);
    if (c_hr) nxt.hour = h24 ? h_enc : {pm, h_enc[6:0]};

    if (c_day) nxt.dow = val_enc((dw_b >= 7'd7) ? 7'd1 : dw_b + 7'd1, bin);

    case (mo_b)
      7'd2:                      dim = (y_b[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase
    c_mon = c_day && (dt_b >= dim);
    if (c_day) nxt.date = val_enc(c_mon ? 7'd1 : dt_b + 7'd1, bin);

    c_yr = c_mon && (mo_b >= 7'd12);
    if (c_mon) nxt.mon = val_enc(c_yr ? 7'd1 : mo_b + 7'd1, bin);
    if (c_yr)  nxt.year = val_enc((y_b >= 7'd99) ? 7'd0 : y_b + 7'd1, bin);
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
#(
  parameter int NF = NUM_ALM
) (
  input  logic [NF-1:0][BYTE_W-1:0] now_v,
  input  logic [NF-1:0][BYTE_W-1:0] alm_v,
  output logic                      hit
);
  logic [NF-1:0] fld_ok;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_ok[g] = (alm_v[g][7:6] == 2'b11) || (alm_v[g] == now_v[g]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
  import rtc_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          rd_clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & en);

  // R10: a source event is never lost, even against a clearing read
  a_r10_set_survives: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[0] |=> flags_q[0]);
  // R10: a read with no new event empties the flags
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> (flags_q == '0));
  // R11: no enable, no request
  a_r11_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_tick,
  input  logic              per_tick,
  input  logic              sqw_src,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sqw_out
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IX_CTRL);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(IX_FLAG);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(IX_SEC);

  byte_t tregs_q [NUM_TREGS];
  byte_t tregs_d [NUM_TREGS];
  byte_t ctrl_q, ctrl_d;

  logic wr_en, rd_en, abort, upd, alm_hit;
  rtc_time_t cur_t, nxt_t;
  logic [NUM_FLAGS-1:0] flags, set_vec;

  assign wr_en = bus_sel && bus_we;
  assign rd_en = bus_sel && !bus_we;
  assign abort = wr_en && (bus_addr == A_CTRL) && bus_wdata[CB_INH];
  assign upd   = upd_tick && !ctrl_q[CB_INH] && !abort;

  assign cur_t = '{sec: tregs_q[IX_SEC], min: tregs_q[IX_MIN], hour: tregs_q[IX_HOUR],
                   dow: tregs_q[IX_DOW], date: tregs_q[IX_DATE], mon: tregs_q[IX_MON],
                   year: tregs_q[IX_YEAR]};

  rtc_advance u_adv (
    .cur (cur_t),
    .bin (ctrl_q[CB_BIN]),
    .h24 (ctrl_q[CB_H24]),
    .nxt (nxt_t)
  );

  rtc_alarm_match #(.NF(NUM_ALM)) u_alm (
    .now_v ({nxt_t.hour, nxt_t.min, nxt_t.sec}),
    .alm_v ({tregs_q[IX_AHOUR], tregs_q[IX_AMIN], tregs_q[IX_ASEC]}),
    .hit   (alm_hit)
  );

  assign set_vec = {per_tick, upd && alm_hit, upd};

  rtc_flags #(.NF(NUM_FLAGS)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .rd_clr  (rd_en && (bus_addr == A_FLAG)),
    .en      (ctrl_q[CB_ENLO+NUM_FLAGS-1:CB_ENLO]),
    .flags   (flags),
    .irq     (irq)
  );

  always_comb begin
    for (int i = 0; i < NUM_TREGS; i++) tregs_d[i] = tregs_q[i];
    ctrl_d = ctrl_q;
    if (upd) begin
      tregs_d[IX_SEC]  = nxt_t.sec;
      tregs_d[IX_MIN]  = nxt_t.min;
      tregs_d[IX_HOUR] = nxt_t.hour;
      tregs_d[IX_DOW]  = nxt_t.dow;
      tregs_d[IX_DATE] = nxt_t.date;
      tregs_d[IX_MON]  = nxt_t.mon;
      tregs_d[IX_YEAR] = nxt_t.year;
    end
    for (int i = 0; i < NUM_TREGS; i++) begin
      if (wr_en && bus_addr == ADDR_W'(i)) tregs_d[i] = bus_wdata;
    end
    if (wr_en && bus_addr == A_CTRL) ctrl_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TREGS; i++) tregs_q[i] <= treg_rst(i);
      ctrl_q <= CTRL_RST;
    end else begin
      for (int i = 0; i < NUM_TREGS; i++) tregs_q[i] <= tregs_d[i];
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      for (int i = 0; i < NUM_TREGS; i++) begin
        if (bus_addr == ADDR_W'(i)) bus_rdata = tregs_q[i];
      end
      if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
      if (bus_addr == A_FLAG) bus_rdata = {irq, flags, 4'b0000};
    end
  end

  assign sqw_out = sqw_src && ctrl_q[CB_SQW];

  // R2: inhibited clock keeps its seconds unless software writes them
  a_r2_hold_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_INH] && !(wr_en && bus_addr == A_SEC)) |=> $stable(tregs_q[IX_SEC]));
  // R2: an accepted tick always moves the seconds byte
  a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && !ctrl_q[CB_INH] && !bus_sel) |=> !$stable(tregs_q[IX_SEC]));
  // R3: setting the inhibit bit cancels the tick of the same cycle
  a_r3_abort_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && wr_en && bus_addr == A_CTRL && bus_wdata[CB_INH]) |=> $stable(tregs_q[IX_SEC]));
  // R12: gated square wave stays low when disabled
  a_r12_sqw_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_SQW] |-> !sqw_out);
endmodule

// File: tb/rtc_core_test.sv
module rtc_core_test;
  logic       clk;
  logic       rst_n;
  logic       upd_tick, per_tick, sqw_src, bus_sel, bus_we;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq, sqw_out;

  int    vectors = 0;
  int    fails   = 0;
  string req     = "R1";

  int m_t [10];
  int m_ctrl;
  bit m_fp, m_fa, m_fu;

  rtc_core #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .per_tick(per_tick),
    .sqw_src(sqw_src), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sqw_out(sqw_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int dcd(int v, bit b);
    return b ? (v & 127) : ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic int ecd(int v, bit b);
    return b ? v : ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic bit m_irq();
    return (m_fp && m_ctrl[6]) || (m_fa && m_ctrl[5]) || (m_fu && m_ctrl[4]);
  endfunction

  function automatic void m_advance();
    bit b, h24, cm, ch, cd, cmo, cy;
    int s, mi, h, pm, dw, dt, mo, y, dim;
    b = m_ctrl[2]; h24 = m_ctrl[1];
    cm = 0; ch = 0; cd = 0; cmo = 0; cy = 0;
    s = dcd(m_t[0], b);
    if (s >= 59) begin s = 0; cm = 1; end else s++;
    m_t[0] = ecd(s, b);
    if (cm) begin
      mi = dcd(m_t[2], b);
      if (mi >= 59) begin mi = 0; ch = 1; end else mi++;
      m_t[2] = ecd(mi, b);
    end
    if (ch) begin
      if (h24) begin
        h = dcd(m_t[4], b);
        if (h >= 23) begin h = 0; cd = 1; end else h++;
        m_t[4] = ecd(h, b);
      end else begin
        h = dcd(m_t[4] & 127, b);
        pm = (m_t[4] >> 7) & 1;
        if (h == 11) begin pm = pm ^ 1; h = 12; cd = (pm == 0); end
        else if (h >= 12) h = 1;
        else h++;
        m_t[4] = (pm << 7) | ecd(h, b);
      end
    end
    if (cd) begin
      dw = dcd(m_t[6], b);
      m_t[6] = ecd((dw >= 7) ? 1 : dw + 1, b);
      dt = dcd(m_t[7], b); mo = dcd(m_t[8], b); y = dcd(m_t[9], b);
      if (mo == 2) dim = (y % 4 == 0) ? 29 : 28;
      else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
      else dim = 31;
      if (dt >= dim) begin dt = 1; cmo = 1; end else dt++;
      m_t[7] = ecd(dt, b);
      if (cmo) begin
        if (mo >= 12) begin mo = 1; cy = 1; end else mo++;
        m_t[8] = ecd(mo, b);
      end
      if (cy) m_t[9] = ecd((y >= 99) ? 0 : y + 1, b);
    end
  endfunction

  function automatic bit m_alarm();
    bit ok;
    ok = 1;
    for (int k = 0; k < 3; k++) begin
      if (!(((m_t[2*k+1] >> 6) & 3) == 3 || m_t[2*k+1] == m_t[2*k])) ok = 0;
    end
    return ok;
  endfunction

  function automatic void m_step(bit tk, bit pt, bit sel, bit we, int adr, int wd);
    bit upd, hit;
    upd = tk && !m_ctrl[7] && !(sel && we && adr == 11 && wd[7]);
    hit = 0;
    if (upd) begin m_advance(); hit = m_alarm(); end
    if (sel && !we && adr == 12) begin m_fp = 0; m_fa = 0; m_fu = 0; end
    if (pt) m_fp = 1;
    if (upd) m_fu = 1;
    if (upd && hit) m_fa = 1;
    if (sel && we) begin
      if (adr < 10) m_t[adr] = wd;
      else if (adr == 11) m_ctrl = wd;
    end
  endfunction

  function automatic int m_read(int adr);
    if (adr < 10) return m_t[adr];
    if (adr == 11) return m_ctrl;
    if (adr == 12) return (int'(m_irq()) << 7) | (int'(m_fp) << 6) | (int'(m_fa) << 5) | (int'(m_fu) << 4);
    return 0;
  endfunction

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit tk, bit pt, bit sq, bit sel, bit we, int adr, int wd);
    upd_tick = tk; per_tick = pt; sqw_src = sq;
    bus_sel = sel; bus_we = we; bus_addr = 4'(adr); bus_wdata = 8'(wd);
    #1;
    check("irq", int'(irq), int'(m_irq()));
    check("sqw_out", int'(sqw_out), int'(sq && m_ctrl[3]));
    if (sel && !we) check($sformatf("rdata[%0h]", adr), int'(bus_rdata), m_read(adr));
    @(posedge clk);
    m_step(tk, pt, sel, we, adr, wd);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);  cyc(0, 0, 0, 1, 1, a, d); endtask
  task automatic rd(int a);         cyc(0, 0, 0, 1, 0, a, 0); endtask
  task automatic tick();            cyc(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd_all();
    for (int a = 0; a < 16; a++) rd(a);
  endtask

  task automatic load(int ctl, int s, int mi, int h, int dw, int dt, int mo, int y);
    wr(11, ctl | 8'h80);
    wr(0, s); wr(2, mi); wr(4, h); wr(6, dw); wr(7, dt); wr(8, mo); wr(9, y);
    wr(11, ctl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    upd_tick = 0; per_tick = 0; sqw_src = 0; bus_sel = 0; bus_we = 0;
    bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 10; i++) m_t[i] = (i == 6 || i == 7 || i == 8) ? 1 : 0;
    m_ctrl = 8'h02; m_fp = 0; m_fa = 0; m_fu = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    req = "R1"; rd_all();

    req = "R4"; load(8'h02, 8'h58, 8'h59, 8'h23, 7, 8'h28, 8'h02, 8'h24);
    tick(); tick(); rd_all();
    req = "R6"; tick(); rd_all();
    req = "R8"; load(8'h02, 8'h59, 8'h59, 8'h23, 3, 8'h29, 8'h02, 8'h24);
    tick(); rd_all();
    load(8'h02, 8'h59, 8'h59, 8'h23, 5, 8'h28, 8'h02, 8'h23); tick(); rd_all();
    load(8'h02, 8'h59, 8'h59, 8'h23, 6, 8'h30, 8'h04, 8'h23); tick(); rd_all();
    load(8'h02, 8'h59, 8'h59, 8'h23, 7, 8'h31, 8'h12, 8'h99); tick(); rd_all();

    req = "R5"; load(8'h06, 59, 59, 23, 2, 31, 1, 99); tick(); rd_all();
    load(8'h06, 59, 59, 23, 4, 28, 12, 99); tick(); rd_all();
    load(8'h06, 59, 59, 23, 4, 31, 12, 99); tick(); rd_all();

    req = "R7"; load(8'h00, 8'h59, 8'h59, 8'h11, 1, 8'h10, 8'h05, 8'h20); tick(); rd_all();
    load(8'h00, 8'h59, 8'h59, 8'h91, 1, 8'h10, 8'h05, 8'h20); tick(); rd_all();
    load(8'h00, 8'h59, 8'h59, 8'h12, 1, 8'h10, 8'h05, 8'h20); tick(); rd_all();
    load(8'h04, 59, 59, 8'h8B, 1, 10, 5, 20); tick(); rd_all();

    req = "R2"; wr(11, 8'h82); tick(); tick(); tick(); rd_all();
    wr(11, 8'h02); tick(); rd(0);

    req = "R3"; rd(12); cyc(1, 0, 0, 1, 1, 11, 8'h82); rd_all(); wr(11, 8'h12);

    req = "R13"; cyc(1, 0, 0, 1, 1, 0, 8'h30); rd_all();
    load(8'h02, 8'h59, 8'h12, 8'h08, 2, 8'h02, 8'h03, 8'h04);
    cyc(1, 0, 0, 1, 1, 0, 8'h45); rd_all();
    wr(1, 8'hA5); wr(3, 8'h5A); wr(5, 8'h3C); wr(11, 8'h0B); rd_all();

    req = "R9"; load(8'h22, 8'h04, 8'h10, 8'h07, 1, 8'h01, 8'h01, 8'h01);
    wr(1, 8'h05); wr(3, 8'hC0); wr(5, 8'hC0); rd(12);
    tick(); rd(12); rd(12);
    wr(1, 8'h07); tick(); rd(12);
    wr(3, 8'h10); wr(5, 8'h08); tick(); rd(12);

    req = "R10"; wr(11, 8'h52); rd(12);
    cyc(0, 1, 0, 0, 0, 0, 0); rd(12); rd(12);
    cyc(1, 1, 0, 0, 0, 0, 0); cyc(1, 1, 0, 1, 0, 12, 0); rd(12); rd(12);

    req = "R11"; wr(11, 8'h02); cyc(1, 1, 0, 0, 0, 0, 0); rd(12);
    wr(11, 8'h42); rd(11); wr(11, 8'h12); rd(11); rd(12);
    req = "R12"; wr(11, 8'h0A);
    for (int i = 0; i < 8; i++) cyc(0, 0, i[0], 0, 0, 0, 0);
    wr(11, 8'h02);
    for (int i = 0; i < 8; i++) cyc(0, 0, i[0], 0, 0, 0, 0);

    req = "R2";
    load(8'h7A, 8'h50, 8'h59, 8'h23, 7, 8'h31, 8'h12, 8'h99);
    for (int i = 0; i < 400; i++)
      cyc(i % 3 == 0, i % 7 == 0, i[1], i % 4 == 1, 0, (i / 4) % 16, 0);
    load(8'h7C, 50, 59, 8'h8B, 7, 31, 12, 99);
    for (int i = 0; i < 400; i++)
      cyc(i % 2 == 0, i % 11 == 0, i[0], i % 5 == 2, 0, (i / 5) % 16, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule